// File: doc/BRIEF.md
# Three-Rotor Byte Substitution Cipher

This block scrambles or restores a stream of bytes at one byte per cycle. Each byte passes through three substitution rotors in series. A rotor first adds its current position to the byte, modulo 256, and then looks the sum up in its own 256-entry permutation. In decrypt mode the same tables are walked backwards: third rotor first, each one an inverse lookup followed by subtracting that rotor's position. Ciphertext produced from a given start state therefore decrypts to the original bytes when the same start state is used.

The rotors move after every accepted byte. Rotor 0 steps on every byte, rotor 1 on every second byte and rotor 2 on every third byte. The distance a rotor moves on each step is the current term of its own Fibonacci sequence, reduced modulo 256. Each sequence is seeded with a pair of integers.

A load port writes the tables, start positions and seeds. A start pulse returns all rotors to the loaded start state, so a new message can begin from that state.

Top module: `tri_rotor_cipher`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In encrypt mode (decrypt=0), with positions p0..p2 and tables T0..T2, the output is T2[T1[T0[x+p0]+p1]+p2]. All sums are taken modulo 256.
- R3: Let k count the bytes accepted since the last start. Rotor r steps after byte k exactly when k is a multiple of r+1 (rotor 0 on every byte, rotor 1 on every 2nd, rotor 2 on every 3rd).
- R4: A step adds the current Fibonacci term a to the position, modulo 256, and then updates (a,b) to (b, a+b mod 256). The sequence does not change on cycles where the rotor does not step.
- R5: In decrypt mode (decrypt=1), the output is x2=inv2[c]-p2, then x1=inv1[x2]-p1, then inv0[x1]-p0, all modulo 256. Decrypting the ciphertext from the same start state returns the plaintext.
- R6: A start pulse sets every position to its loaded start value, every sequence to its seeds (a=seed A, b=seed B), and clears the step phase counters.
- R7: While out_valid=1 and out_ready=0, out_data holds, in_ready is 0, and no rotor moves.
- R8: ld_kind selects what the load port writes: 0 writes table entry ld_addr of rotor ld_rotor with value ld_data; 1 writes the start position; 2 writes seed A; 3 writes seed B. in_ready is 0 while ld_valid or start is high.
- R9: A byte accepted at a clock edge appears on out_data, with out_valid=1, after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Restore the loaded start state |
| decrypt | input | 1 | 1 selects the inverse path |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | 8 | Output byte |
| ld_valid | input | 1 | Load write strobe |
| ld_kind | input | 2 | Load target: table, start, seed A, seed B |
| ld_rotor | input | 2 | Rotor index 0..2 |
| ld_addr | input | 8 | Table index |
| ld_data | input | 8 | Value written |

## Verification
The hardest situation to reach is a sequence term that has wrapped modulo 256 while all three rotors sit at unrelated phases of their step rates. Only long runs of accepted bytes get there. The bench streams 300 bytes through distinct affine permutations, with seeds chosen so that the sequences overflow within a few dozen steps. It compares every byte with an arithmetic model, then decrypts the ciphertext back. A stall with out_ready held low is placed in the middle of the phase pattern, so that any movement of the rotors during backpressure would show up on the next byte.

// File: rtl/rotor_pkg.sv
package rotor_pkg;
  localparam int DW   = 8;
  localparam int NROT = 3;
  localparam int TDEP = 1 << DW;

  typedef enum logic [1:0] {
    LD_TABLE = 2'd0,
    LD_START = 2'd1,
    LD_SEEDA = 2'd2,
    LD_SEEDB = 2'd3
  } ld_kind_e;

  function automatic logic [DW-1:0] add8(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] sub8(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction
endpackage

// File: rtl/rotor_table.sv
module rotor_table
  import rotor_pkg::*;
(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] fwd_idx,
  output logic [DW-1:0] fwd_q,
  input  logic [DW-1:0] inv_idx,
  output logic [DW-1:0] inv_q
);
  logic [DW-1:0] fwd_mem [TDEP];
  logic [DW-1:0] inv_mem [TDEP];

  // forward entry and its inverse are written together
  always_ff @(posedge clk) begin
    if (wr_en) begin
      fwd_mem[wr_addr] <= wr_data;
      inv_mem[wr_data] <= wr_addr;
    end
  end

  assign fwd_q = fwd_mem[fwd_idx];
  assign inv_q = inv_mem[inv_idx];
endmodule

// File: rtl/rotor_stepper.sv
module rotor_stepper
  import rotor_pkg::*;
#(
  parameter int RATE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          start_we,
  input  logic          seeda_we,
  input  logic          seedb_we,
  input  logic [DW-1:0] cfg_data,
  output logic [DW-1:0] pos,
  output logic          step
);
  localparam int PW = (RATE > 1) ? $clog2(RATE) : 1;

  logic [DW-1:0] start_pos, seed_a, seed_b, fa, fb;
  logic [PW-1:0] phase;

  assign step = adv && (phase == PW'(RATE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pos <= '0;
      seed_a    <= '0;
      seed_b    <= '0;
    end else begin
      if (start_we) start_pos <= cfg_data;
      if (seeda_we) seed_a    <= cfg_data;
      if (seedb_we) seed_b    <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      fa    <= '0;
      fb    <= '0;
      phase <= '0;
    end else if (start) begin
      pos   <= start_pos;
      fa    <= seed_a;
      fb    <= seed_b;
      phase <= '0;
    end else if (adv) begin
      phase <= step ? '0 : phase + 1'b1;
      if (step) begin
        pos <= add8(pos, fa);
        fa  <= fb;
        fb  <= add8(fa, fb);
      end
    end
  end

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !start |=> $stable(pos));
  // R4
  fib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !start |=> $stable(fa) && $stable(fb));
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pos == $past(start_pos) && fa == $past(seed_a) && fb == $past(seed_b));
endmodule

// File: rtl/tri_rotor_cipher.sv
module tri_rotor_cipher
  import rotor_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       decrypt,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  input  logic       ld_valid,
  input  logic [1:0] ld_kind,
  input  logic [1:0] ld_rotor,
  input  logic [7:0] ld_addr,
  input  logic [7:0] ld_data
);
  logic [DW-1:0] enc_link [NROT+1];
  logic [DW-1:0] dec_link [NROT+1];
  logic [DW-1:0] inv_q    [NROT];
  logic [DW-1:0] pos      [NROT];
  logic [NROT-1:0] step;
  logic accept;

  assign in_ready = (!out_valid || out_ready) && !start && !ld_valid;
  assign accept   = in_valid && in_ready;

  assign enc_link[0]    = in_data;
  assign dec_link[NROT] = in_data;

  for (genvar r = 0; r < NROT; r++) begin : g_rot
    logic sel;
    assign sel = ld_valid && (ld_rotor == 2'(r));

    rotor_table u_tbl (
      .clk     (clk),
      .wr_en   (sel && ld_kind == LD_TABLE),
      .wr_addr (ld_addr),
      .wr_data (ld_data),
      .fwd_idx (add8(enc_link[r], pos[r])),
      .fwd_q   (enc_link[r+1]),
      .inv_idx (dec_link[r+1]),
      .inv_q   (inv_q[r])
    );

    assign dec_link[r] = sub8(inv_q[r], pos[r]);

    rotor_stepper #(.RATE(r + 1)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .adv      (accept),
      .start_we (sel && ld_kind == LD_START),
      .seeda_we (sel && ld_kind == LD_SEEDA),
      .seedb_we (sel && ld_kind == LD_SEEDB),
      .cfg_data (ld_data),
      .pos      (pos[r]),
      .step     (step[r])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= decrypt ? dec_link[0] : enc_link[NROT];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || ld_valid) |-> !in_ready);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R3
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> step[0]);
endmodule

// File: tb/tri_rotor_cipher_bench.sv
module tri_rotor_cipher_bench;
  localparam int N = 300;

  logic clk = 0, rst_n = 0, start = 0, decrypt = 0, in_valid = 0, out_ready = 1, ld_valid = 0;
  logic [7:0] in_data = 0, ld_addr = 0, ld_data = 0;
  logic [1:0] ld_kind = 0, ld_rotor = 0;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  int mulk [3] = '{5, 37, 109};
  int addk [3] = '{8'h13, 8'h7A, 8'hC1};
  int spos [3] = '{3, 200, 77};
  int sda  [3] = '{1, 2, 13};
  int sdb  [3] = '{1, 5, 250};
  int bpos [3], bfa [3], bfb [3];
  int bcnt;
  logic [7:0] pt [N], ct [N], expv [N];

  always #4 clk = ~clk;

  tri_rotor_cipher u_tri_rotor_cipher (.*);

  task automatic check(string req, int act, int expct);
    checks++;
    if (act != expct) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expct);
    end
  endtask

  function automatic int tbl(int r, int i);
    return (i * mulk[r] + addk[r]) & 255;
  endfunction

  function automatic int itbl(int r, int v);
    for (int j = 0; j < 256; j++) if (tbl(r, j) == v) return j;
    return -1;
  endfunction

  function automatic int m_enc(int x);
    int v = x;
    for (int r = 0; r < 3; r++) v = tbl(r, (v + bpos[r]) & 255);
    return v;
  endfunction

  function automatic int m_dec(int c);
    int v = c;
    for (int r = 2; r >= 0; r--) v = (itbl(r, v) - bpos[r]) & 255;
    return v;
  endfunction

  task automatic m_reset();
    for (int r = 0; r < 3; r++) begin bpos[r] = spos[r]; bfa[r] = sda[r]; bfb[r] = sdb[r]; end
    bcnt = 0;
  endtask

  task automatic m_step();
    bcnt++;
    for (int r = 0; r < 3; r++)
      if (bcnt % (r + 1) == 0) begin
        int t = bfa[r];
        bpos[r] = (bpos[r] + bfa[r]) & 255;
        bfa[r] = bfb[r];
        bfb[r] = (t + bfb[r]) & 255;
      end
  endtask

  task automatic load(int kind, int rot, int addr, int data);
    @(negedge clk);
    ld_valid = 1; ld_kind = 2'(kind); ld_rotor = 2'(rot); ld_addr = 8'(addr); ld_data = 8'(data);
    #1;
    if (addr == 0) check("R8 in_ready low during load", in_ready, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    ld_valid = 0; start = 1;
    #1 check("R8 in_ready low during start", in_ready, 0);
    @(negedge clk);
    start = 0;
    m_reset();
  endtask

  // streams n bytes from src at one per cycle; decrypt mode checks against plaintext
  task automatic stream(bit dec, int n, string req);
    decrypt = dec;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(req, out_valid, 1);
        check(req, out_data, expv[k-1]);
      end
      if (k < n) begin
        check("R9 in_ready while streaming", in_ready, 1);
        in_valid = 1;
        in_data = dec ? ct[k] : pt[k];
        if (dec) begin
          check("R5 model inverse", m_dec(ct[k]), pt[k]);
          expv[k] = pt[k];
        end else expv[k] = 8'(m_enc(pt[k]));
        m_step();
      end else in_valid = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 1);
    rst_n = 1;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 256; i++) load(0, r, i, tbl(r, i));
      load(1, r, 1, spos[r]);
      load(2, r, 1, sda[r]);
      load(3, r, 1, sdb[r]);
    end
    load(1, 3, 1, 99);  // rotor index 3 selects nothing
    // R2 R3 R4: ramp plaintext, all 256 values plus wrap
    for (int k = 0; k < N; k++) pt[k] = 8'(k * 7 + 1);
    pulse_start();
    stream(0, N, "R2 R3 R4 encrypt ramp");
    for (int k = 0; k < N; k++) ct[k] = expv[k];
    // R5 R6: restart and decrypt back
    pulse_start();
    stream(1, N, "R5 R6 decrypt returns plaintext");
    // R3 R4: constant plaintext shows only the stepping
    for (int k = 0; k < 60; k++) pt[k] = 8'h00;
    pulse_start();
    stream(0, 60, "R3 R4 encrypt constant");
    // R7: backpressure mid-phase
    pulse_start();
    stream(0, 5, "R2 pre-stall");
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_data = 8'h5A; decrypt = 0;
    expv[0] = 8'(m_enc(8'h5A)); m_step();
    @(negedge clk);
    in_data = 8'hC3;
    for (int i = 0; i < 3; i++) begin
      check("R7 out_valid held", out_valid, 1);
      check("R7 out_data held", out_data, expv[0]);
      check("R7 in_ready low", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1;
    #1 check("R7 in_ready on release", in_ready, 1);
    expv[1] = 8'(m_enc(8'hC3)); m_step();
    @(negedge clk);
    in_valid = 0;
    check("R7 R9 byte after stall", out_data, expv[1]);
    check("R9 valid after stall", out_valid, 1);
    @(negedge clk);
    check("R9 valid drops", out_valid, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule